// File: doc/BRIEF.md
# Word-to-Byte RAM Port Bridge

This block joins a compute core that addresses its RAM by word index to a memory that takes byte addresses and per-byte write strobes. The core side has a chip-enable, a write-enable, a narrow word index, write data, optional lane strobes and read data. The memory side has a single access enable, a 32-bit byte address, one write strobe per byte lane, and write and read data that are a power-of-two number of bytes wide.

Each core access goes out to memory in the same cycle. The word index is multiplied by the memory word size in bytes. Write data is zero-padded up to the memory width, and lane strobes are built from the core's write-enable and byte enables. The memory answers reads after a fixed number of cycles set by a parameter. A tag pipeline of that length marks the returning words, so the core receives its read data with a valid flag in exactly that cycle. Between returns, the last word read stays on the core data output.

Top module: `word_byte_ram_bridge`

## Requirements
- R1: For core word index n, `mem_addr` equals n multiplied by MEM_BYTES, zero-extended to 32 bits. MEM_BYTES is the memory word width divided by 8.
- R2: `mem_en` equals `core_ce` in the same cycle, except that no memory access is driven while `rst_n` is low.
- R3: A write (`core_ce` and `core_we` high) sets strobe bit i of `mem_be` from `core_be[i]` for each core byte lane i, when the core width is a multiple of 8. Strobe bits for pad lanes above the core width are set on every write. A read (`core_ce` high, `core_we` low) drives `mem_be` to all zeros.
- R4: When the core width is not a multiple of 8, `core_be` is ignored, and every write sets every bit of `mem_be`.
- R5: The memory word width is the smallest 8·2^k that is at least the core width. `mem_wdata` carries `core_wdata` in its low bits, and all bits above the core width are zero.
- R6: `core_rvalid` is high exactly RD_LAT cycles after each read is issued, and at no other time. Reads may be issued one per cycle.
- R7: In a cycle with `core_rvalid` high, `core_rdata` equals the low core-width bits of `mem_rdata`. Otherwise `core_rdata` holds the last returned word.
- R8: Writes never raise `core_rvalid` and never change `core_rdata`.
- R9: Reset empties the tag pipeline, so reads in flight when reset is asserted never return. Reset also clears `core_rdata` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_ce | input | 1 | Core access request |
| core_we | input | 1 | Core write select (read when low) |
| core_addr | input | AW | Word index, AW = ceil(log2(DEPTH)) |
| core_wdata | input | CORE_W | Core write data |
| core_be | input | BEW | Core byte-lane enables (used only if CORE_W is a multiple of 8) |
| core_rdata | output | CORE_W | Returned read data |
| core_rvalid | output | 1 | Read data valid this cycle |
| mem_en | output | 1 | Memory access enable |
| mem_be | output | MEM_BYTES | Per-byte write strobes |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | MEM_W | Padded write data |
| mem_rdata | input | MEM_W | Memory read data, RD_LAT cycles after request |

## Verification
On every cycle, the assertions check four things. No access leaves the bridge during reset. Reads carry no write strobes, and pad lanes are strobed on writes. Byte addresses stay aligned and inside the scaled range. The count of reads in flight never exceeds RD_LAT, and a valid return never appears with nothing in flight. Only the bench's scenarios can show the exact return cycle of each read in a back-to-back burst and which stored word comes back. They also show how partial writes merge into memory contents, that a reset drops reads already in flight, and that an ignored strobe input has no effect on the non-byte-multiple configuration.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  // Smallest 8 * 2^k that holds core_w bits.
  function automatic int mem_word_bits(input int core_w);
    int w;
    w = 8;
    for (int i = 0; i < 16; i++) begin
      if (w < core_w) w = w * 2;
    end
    return w;
  endfunction

  function automatic int index_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // Number of whole byte lanes on the core side; zero when not byte aligned.
  function automatic int core_lanes(input int core_w);
    return ((core_w % 8) == 0) ? (core_w / 8) : 0;
  endfunction

  function automatic int strobe_bits(input int core_w);
    return (core_w >= 8) ? (core_w / 8) : 1;
  endfunction

  // Word index to byte address.
  function automatic logic [31:0] word_to_byte(input logic [31:0] idx, input int bytes);
    return idx * 32'(bytes);
  endfunction

endpackage

// File: rtl/ram_addr_scale.sv
module ram_addr_scale
  import bridge_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int MB    = 4,
  localparam int AW   = index_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] core_addr_i,
  output logic [31:0]   mem_addr_o
);

  assign mem_addr_o = word_to_byte(32'(core_addr_i), MB);

  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr_o % MB) == 0);

  p_addr_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_o < 32'((1 << AW) * MB));

endmodule

// File: rtl/ram_lane_enable.sv
module ram_lane_enable
  import bridge_pkg::*;
#(
  parameter int CORE_W  = 24,
  localparam int MEM_W  = mem_word_bits(CORE_W),
  localparam int MB     = MEM_W / 8,
  localparam int LANES  = core_lanes(CORE_W),
  localparam int BEW    = strobe_bits(CORE_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [BEW-1:0] core_be_i,
  output logic [MB-1:0]  mem_be_o
);

  for (genvar l = 0; l < MB; l++) begin : g_lane
    if (l < LANES) begin : g_core_lane
      assign mem_be_o[l] = wr_i & core_be_i[l];
    end else begin : g_pad_lane
      assign mem_be_o[l] = wr_i;
    end
  end

  if (LANES == 0) begin : g_no_strobes
    logic unused_be;
    assign unused_be = ^core_be_i;

    p_full_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |-> (&mem_be_o));
  end else if (LANES < MB) begin : g_pad_check
    p_pad_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |-> (&mem_be_o[MB-1:LANES]));
  end

endmodule

// File: rtl/ram_read_align.sv
module ram_read_align
  import bridge_pkg::*;
#(
  parameter int CORE_W = 24,
  parameter int RD_LAT = 2,
  localparam int MEM_W = mem_word_bits(CORE_W),
  localparam int IW    = $clog2(RD_LAT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [MEM_W-1:0]  mem_rdata_i,
  output logic              rvalid_o,
  output logic [CORE_W-1:0] rdata_o
);

  logic [RD_LAT-1:0] tag_q;
  logic [CORE_W-1:0] hold_q;
  logic [CORE_W-1:0] ret_word;
  logic [IW-1:0]     inflight_q;

  if (RD_LAT == 1) begin : g_lat1
    always_ff @(posedge clk) begin
      if (!rst_n) tag_q <= '0;
      else        tag_q <= issue_i;
    end
  end else begin : g_latn
    always_ff @(posedge clk) begin
      if (!rst_n) tag_q <= '0;
      else        tag_q <= {tag_q[RD_LAT-2:0], issue_i};
    end
  end

  if (MEM_W > CORE_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^mem_rdata_i[MEM_W-1:CORE_W];
  end

  assign ret_word = mem_rdata_i[CORE_W-1:0];
  assign rvalid_o = tag_q[RD_LAT-1];
  assign rdata_o  = rvalid_o ? ret_word : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        hold_q <= '0;
    else if (rvalid_o) hold_q <= ret_word;
  end

  // Outstanding reads, kept for the properties below.
  always_ff @(posedge clk) begin
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_q + IW'(issue_i) - IW'(rvalid_o);
  end

  p_inflight_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inflight_q) <= RD_LAT);

  p_no_orphan_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight_q == '0) |-> !rvalid_o);

  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid_o |=> (!rvalid_o |-> $stable(rdata_o)));

endmodule

// File: rtl/word_byte_ram_bridge.sv
module word_byte_ram_bridge
  import bridge_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int CORE_W  = 24,
  parameter int RD_LAT  = 2,
  localparam int AW     = index_bits(DEPTH),
  localparam int MEM_W  = mem_word_bits(CORE_W),
  localparam int MB     = MEM_W / 8,
  localparam int BEW    = strobe_bits(CORE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_ce,
  input  logic              core_we,
  input  logic [AW-1:0]     core_addr,
  input  logic [CORE_W-1:0] core_wdata,
  input  logic [BEW-1:0]    core_be,
  output logic [CORE_W-1:0] core_rdata,
  output logic              core_rvalid,
  output logic              mem_en,
  output logic [MB-1:0]     mem_be,
  output logic [31:0]       mem_addr,
  output logic [MEM_W-1:0]  mem_wdata,
  input  logic [MEM_W-1:0]  mem_rdata
);

  logic wr_evt;
  logic rd_evt;

  assign mem_en = core_ce & rst_n;
  assign wr_evt = mem_en & core_we;
  assign rd_evt = mem_en & ~core_we;

  ram_addr_scale #(.DEPTH(DEPTH), .MB(MB)) u_addr (
    .clk(clk), .rst_n(rst_n), .core_addr_i(core_addr), .mem_addr_o(mem_addr)
  );

  ram_lane_enable #(.CORE_W(CORE_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_evt), .core_be_i(core_be), .mem_be_o(mem_be)
  );

  assign mem_wdata = MEM_W'(core_wdata);

  ram_read_align #(.CORE_W(CORE_W), .RD_LAT(RD_LAT)) u_align (
    .clk(clk), .rst_n(rst_n), .issue_i(rd_evt), .mem_rdata_i(mem_rdata),
    .rvalid_o(core_rvalid), .rdata_o(core_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r2: assert (!mem_en);
    end
  end

  p_read_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ce && !core_we) |-> (mem_be == '0));

  if (MEM_W > CORE_W) begin : g_pad
    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wdata[MEM_W-1:CORE_W] == '0);
  end

endmodule

// File: tb/tb_word_byte_ram_bridge.sv
module tb_word_byte_ram_bridge;

  localparam int L = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_ce = 1'b0, core_we = 1'b0;
  logic [3:0]  core_addr = '0;
  logic [23:0] core_wdata = '0;
  logic [2:0]  core_be = '0;
  logic [23:0] core_rdata;
  logic        core_rvalid, mem_en;
  logic [3:0]  mem_be;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic        o_ce = 1'b0, o_we = 1'b0;
  logic [2:0]  o_addr = '0;
  logic [11:0] o_wdata = '0, o_rdata;
  logic [0:0]  o_be = '0;
  logic        o_rvalid, o_en;
  logic [1:0]  o_mbe;
  logic [31:0] o_maddr;
  logic [15:0] o_mwdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [23:0] expw [16];

  always #5 clk = ~clk;

  word_byte_ram_bridge #(.DEPTH(16), .CORE_W(24), .RD_LAT(L)) dut (
    .clk(clk), .rst_n(rst_n), .core_ce(core_ce), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_be(core_be),
    .core_rdata(core_rdata), .core_rvalid(core_rvalid), .mem_en(mem_en),
    .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  word_byte_ram_bridge #(.DEPTH(8), .CORE_W(12), .RD_LAT(1)) dut_odd (
    .clk(clk), .rst_n(rst_n), .core_ce(o_ce), .core_we(o_we),
    .core_addr(o_addr), .core_wdata(o_wdata), .core_be(o_be),
    .core_rdata(o_rdata), .core_rvalid(o_rvalid), .mem_en(o_en),
    .mem_be(o_mbe), .mem_addr(o_maddr), .mem_wdata(o_mwdata), .mem_rdata(16'hABCD)
  );

  // Byte-addressed memory model with L-cycle read latency.
  logic [31:0] ram [16];
  logic [31:0] q0 = '0, q1 = '0;
  initial for (int i = 0; i < 16; i++) ram[i] = '0;
  always @(posedge clk) begin
    if (mem_en) begin
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) ram[mem_addr[5:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
      if (mem_be == 4'h0) q0 <= ram[mem_addr[5:2]];
    end
    q1 <= q0;
  end
  assign mem_rdata = q1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [23:0] full_pat(input int n);
    return 24'((n + 1) * 32'h000B1D3F);
  endfunction

  function automatic logic [23:0] part_pat(input int n);
    return 24'h5A5A5A ^ 24'(n * 32'h00111111);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Reset state (R2, R9)
    core_ce = 1'b1; o_ce = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R2 mem_en low in reset", mem_en, 0);
    check("R2 odd mem_en low in reset", o_en, 0);
    check("R9 rvalid low in reset", core_rvalid, 0);
    check("R9 rdata cleared", core_rdata, 0);
    @(negedge clk);
    rst_n = 1'b1; core_ce = 1'b0; o_ce = 1'b0;

    // Full-word writes over every index (R1, R2, R3, R5)
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      core_ce = 1'b1; core_we = 1'b1; core_addr = 4'(n);
      core_wdata = full_pat(n); core_be = 3'b111;
      expw[n] = full_pat(n);
      #1;
      check("R2 mem_en follows ce", mem_en, 1);
      check("R1 byte address", mem_addr, 64'(n * 4));
      check("R3 full strobes", mem_be, 4'hF);
      check("R5 padded wdata", mem_wdata, {8'h00, full_pat(n)});
    end

    // Partial writes, every strobe pattern (R3)
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      core_ce = 1'b1; core_we = 1'b1; core_addr = 4'(n);
      core_wdata = part_pat(n); core_be = 3'(n);
      for (int l = 0; l < 3; l++)
        if (n[l]) expw[n][8*l +: 8] = part_pat(n)[8*l +: 8];
      #1;
      check("R3 partial strobes", mem_be, {1'b1, 3'(n)});
    end

    // Back-to-back reads of every index (R3, R6, R7)
    for (int i = 0; i < 16 + L + 1; i++) begin
      @(negedge clk);
      if (i >= L && (i - L) < 16) begin
        check("R6 rvalid on return cycle", core_rvalid, 1);
        check("R7 returned word", core_rdata, expw[i - L]);
      end else begin
        check("R6 no rvalid", core_rvalid, 0);
      end
      if (i < 16) begin
        core_ce = 1'b1; core_we = 1'b0; core_addr = 4'(i); core_be = 3'b111;
        #1;
        check("R3 read has no strobes", mem_be, 0);
        check("R1 read byte address", mem_addr, 64'(i * 4));
      end else begin
        core_ce = 1'b0;
      end
    end
    @(negedge clk);
    check("R7 rdata held after burst", core_rdata, expw[15]);

    // A write produces no return (R8)
    core_ce = 1'b1; core_we = 1'b1; core_addr = 4'd2; core_wdata = 24'h123456; core_be = 3'b111;
    @(negedge clk);
    core_ce = 1'b0;
    for (int k = 0; k < L + 1; k++) begin
      check("R8 write raises no rvalid", core_rvalid, 0);
      check("R8 rdata unchanged by write", core_rdata, expw[15]);
      @(negedge clk);
    end

    // Read in flight dropped by reset (R9, R2)
    core_ce = 1'b1; core_we = 1'b0; core_addr = 4'd5;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R2 no access while reset with ce high", mem_en, 0);
    @(negedge clk);
    rst_n = 1'b1; core_ce = 1'b0;
    for (int k = 0; k < L + 1; k++) begin
      check("R9 flushed read never returns", core_rvalid, 0);
      check("R9 rdata zero after reset", core_rdata, 0);
      @(negedge clk);
    end

    // Non-byte-multiple core width (R1, R4, R5, R6)
    o_ce = 1'b1; o_we = 1'b1; o_addr = 3'd5; o_wdata = 12'hFFF; o_be = 1'b0;
    #1;
    check("R4 strobe input ignored", o_mbe, 2'b11);
    check("R5 odd pad bits zero", o_mwdata, 16'h0FFF);
    check("R1 odd byte address", o_maddr, 10);
    @(negedge clk);
    o_we = 1'b0; o_addr = 3'd7;
    #1;
    check("R3 odd read no strobes", o_mbe, 0);
    @(negedge clk);
    o_ce = 1'b0;
    check("R6 odd single-cycle return", o_rvalid, 1);
    check("R7 odd returned word", o_rdata, 12'hBCD);
    @(negedge clk);
    check("R6 odd no extra return", o_rvalid, 0);

    finish_run();
  end

endmodule